// File: doc/BRIEF.md
# SPI Master Word Shifter

This block moves one SPI word at a time as a bus master. It reads each outgoing word from the head of a show-ahead transmit FIFO and hands every completed incoming word to a receive FIFO write port. A 32-bit control word selects the clock polarity, the clock phase, an internal loopback path, and a run-time word length of 4 to 32 bits. The block drives the serial clock, the data-out line and one active-low select, samples the data-in line, and reports a busy flag.

The serial clock rate comes from an external divider. Each one-cycle pulse on `sclk_tick` marks one half period of the serial clock. Words are sent back to back under a single select assertion for as long as the transmit FIFO has data and the block is enabled. Clearing the enable lets the word in flight finish and stops the block at the next word boundary.

Top module: `spi_shift_engine`

## Requirements
- R1: After a synchronous reset, `cs_n` is 1, `sclk` is 0, `busy` is 0, and `tx_pop` and `rx_push` are 0.
- R2: Data on `mosi` goes out MSB first. Exactly the low L bits of the transmit word are sent, where L is the word length.
- R3: Each received word is assembled MSB first from `miso`, right-aligned in `rx_data` with the unused upper bits 0, and delivered with a one-cycle `rx_push` pulse.
- R4: When control bit 1 (loopback) is 1, the receive shifter samples the bit the block is driving on `mosi` and ignores `miso`.
- R5: Whenever `cs_n` is 1, `sclk` rests at the level of control bit 2 (polarity), following it one cycle later.
- R6: Control bit 3 selects the phase. With 0, the first bit is on `mosi` when `cs_n` falls and is sampled on the first clock edge of the word. With 1, data changes on odd edges and is sampled on even edges. `sclk` only changes on a `sclk_tick` cycle.
- R7: Control bits 24:20 hold the word length minus one (3 to 31, giving 4 to 32 bits). Codes 0 to 2 are treated as 4 bits.
- R8: The block receives one word for every word it pops from the transmit FIFO, and `rx_push` pulses are never adjacent.
- R9: `busy` is 1 while `cs_n` is 0, and also whenever `en` is 1 and `tx_empty` is 0.
- R10: With `en` at 0, no new word is popped. A word already in flight completes, `cs_n` then returns to 1, and the remaining FIFO contents stay in place.
- R11: A word is popped only when `en` is 1, control bit 25 (mode) is 1 and `tx_empty` is 0. With the mode bit at 0, nothing starts.
- R12: `cs_n` stays 0 between back-to-back words. It rises one half period (one `sclk_tick`) after the last edge of the final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| ctrl | input | 32 | Control word (loopback, polarity, phase, length, mode) |
| sclk_tick | input | 1 | Half-period pulse from the clock divider |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 32 | Transmit FIFO head word (show-ahead) |
| tx_pop | output | 1 | Consume the transmit FIFO head |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | 32 | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |
| busy | output | 1 | Busy status |

## Verification
In a back-to-back burst, the final edge of one word (which samples its last bit and raises `rx_push`) falls on the same tick that pops and loads the next word. With phase 1, the outgoing line already shows the new word's MSB when the old word's last bit is sampled. The bench provokes this with multi-word bursts in every polarity and phase combination. A scoreboard then requires every received word to match its queued expectation and every captured outgoing word to match, in order. A second collision comes from dropping the enable during the first word of a burst: the in-flight word must complete on its boundary while no further pop happens, which the bench judges by pop and push counts and by the FIFO contents left behind.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int WORD_MAX = 32;
    localparam int LEN_W    = 5;
    localparam int LEN_MIN  = 4;

    // control word bit positions (software-visible layout)
    localparam int B_LOOP  = 1;
    localparam int B_CPOL  = 2;
    localparam int B_CPHA  = 3;
    localparam int B_LEN_L = 20;
    localparam int B_MODE  = 25;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic             mode;
        logic             loop;
        logic             cpol;
        logic             cpha;
        logic [LEN_W-1:0] len_m1;
    } word_cfg_t;

    function automatic word_cfg_t decode_ctrl(input logic [31:0] c);
        word_cfg_t r;
        r.mode   = c[B_MODE];
        r.loop   = c[B_LOOP];
        r.cpol   = c[B_CPOL];
        r.cpha   = c[B_CPHA];
        r.len_m1 = c[B_LEN_L +: LEN_W];
        if (r.len_m1 < LEN_W'(LEN_MIN - 1))
            r.len_m1 = LEN_W'(LEN_MIN - 1);
        return r;
    endfunction
endpackage

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          go,
    input  logic          cpol_now,
    input  logic          cpha_in,
    input  logic [LW-1:0] len_m1_in,
    output logic          load,
    output logic          shift,
    output logic          sample,
    output logic          last,
    output logic          sclk,
    output logic          cs_n
);
    localparam int CW = LW + 2;

    seq_state_t    st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic [CW-1:0] two_l;
    logic [LW-1:0] len_q;
    logic          cpha_q;
    logic          ev;
    logic          odd;

    always_comb begin
        nxt    = cnt + CW'(1);
        two_l  = CW'({len_q, 1'b0}) + CW'(2);
        ev     = tick && (st == ST_SHIFT);
        odd    = nxt[0];
        last   = ev && (nxt == two_l);
        sample = ev && (cpha_q ? !odd : odd);
        shift  = ev && !last && (cpha_q ? (odd && nxt != CW'(1)) : !odd);
        load   = go && tick && ((st == ST_IDLE) || last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
            cpha_q <= 1'b0;
            len_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    sclk <= cpol_now;
                    if (load) begin
                        st   <= ST_SHIFT;
                        cs_n <= 1'b0;
                        cnt  <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (ev) begin
                        sclk <= ~sclk;
                        cnt  <= nxt;
                        if (last) begin
                            if (load) cnt <= '0;
                            else      st  <= ST_TAIL;
                        end
                    end
                    if (load) sclk <= cpol_now;
                end
                default: begin
                    if (tick) begin
                        cs_n <= 1'b1;
                        st   <= ST_IDLE;
                        sclk <= cpol_now;
                    end
                end
            endcase
            if (load) begin
                cpha_q <= cpha_in;
                len_q  <= len_m1_in;
            end
        end
    end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int DW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] tx_word,
    input  logic [LW-1:0] len_m1,
    input  logic          loop_in,
    input  logic          shift,
    input  logic          sample,
    input  logic          last,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_word,
    output logic          rx_push
);
    logic [DW-1:0] tx_sh;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] rx_nx;
    logic [LW-1:0] lalign;
    logic          loop_q;
    logic          in_bit;

    assign mosi   = tx_sh[DW-1];
    assign in_bit = loop_q ? mosi : miso;
    assign lalign = LW'(DW - 1) - len_m1;
    assign rx_nx  = sample ? {rx_sh[DW-2:0], in_bit} : rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_word <= '0;
            rx_push <= 1'b0;
            loop_q  <= 1'b0;
        end else begin
            rx_push <= last;
            if (last) rx_word <= rx_nx;
            rx_sh <= load ? '0 : rx_nx;
            if (load) begin
                tx_sh  <= tx_word << lalign;
                loop_q <= loop_in;
            end else if (shift) begin
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DW = WORD_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [31:0]   ctrl,
    input  logic          sclk_tick,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n,
    output logic          busy
);
    localparam int LW = $clog2(DW);

    word_cfg_t cfg;
    logic      go;
    logic      load;
    logic      shift;
    logic      sample;
    logic      last;

    assign cfg    = decode_ctrl(ctrl);
    assign go     = en && cfg.mode && !tx_empty;
    assign tx_pop = load;
    assign busy   = !cs_n || (en && !tx_empty);

    spi_eng_seq #(.LW(LW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (sclk_tick),
        .go        (go),
        .cpol_now  (cfg.cpol),
        .cpha_in   (cfg.cpha),
        .len_m1_in (cfg.len_m1[LW-1:0]),
        .load      (load),
        .shift     (shift),
        .sample    (sample),
        .last      (last),
        .sclk      (sclk),
        .cs_n      (cs_n)
    );

    spi_eng_shift #(.DW(DW), .LW(LW)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .tx_word (tx_data),
        .len_m1  (cfg.len_m1[LW-1:0]),
        .loop_in (cfg.loop),
        .shift   (shift),
        .sample  (sample),
        .last    (last),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_data),
        .rx_push (rx_push)
    );
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic [31:0] ctrl,
    input logic        sclk_tick,
    input logic        tx_empty,
    input logic        tx_pop,
    input logic        rx_push,
    input logic        sclk,
    input logic        cs_n,
    input logic        busy
);
    assert_pop_gated_R11: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (en && ctrl[25] && !tx_empty));

    assert_no_pop_disabled_R10: assert property (@(posedge clk) disable iff (rst)
        !en |-> !tx_pop);

    assert_busy_pending_R9: assert property (@(posedge clk) disable iff (rst)
        (en && !tx_empty) |-> busy);

    assert_busy_selected_R9: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    assert_sclk_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && !$stable(sclk)) |-> $past(sclk_tick));

    assert_cs_held_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_pop && !cs_n) |=> !cs_n);

    assert_push_spaced_R8: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_push);

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(cs_n)) |-> (sclk == $past(ctrl[2])));
endmodule

bind spi_shift_engine spi_eng_chk u_chk (.*);

// File: tb/sim_spi_shift_engine.sv
`timescale 1ns/1ps
module sim_spi_shift_engine;
    localparam logic [31:0] SLV = 32'hC3A5_96E1;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        sclk_tick = 1'b0;
    logic        tx_empty = 1'b1;
    logic [31:0] tx_data = '0;
    logic        miso = 1'b0;
    logic        tx_pop, rx_push, sclk, mosi, cs_n, busy;
    logic [31:0] rx_data;

    logic       c_mode = 1'b1, c_loop = 1'b0, c_cpol = 1'b0, c_cpha = 1'b0;
    logic [4:0] c_len = 5'd7;
    logic [31:0] ctrl;
    assign ctrl = {6'b0, c_mode, c_len, 16'b0, c_cpha, c_cpol, c_loop, 1'b0};

    int n_chk = 0, n_fail = 0, n_pop = 0, n_push = 0, cs_rise = 0, cyc = 0;
    logic [31:0] txq[$];
    logic [31:0] exp_mosi[$];
    logic [31:0] exp_rx[$];
    logic pop_pend = 1'b0;
    int divc = 0;

    always #2.5 clk = ~clk;

    spi_shift_engine u0 (
        .clk(clk), .rst(rst), .en(en), .ctrl(ctrl), .sclk_tick(sclk_tick),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .busy(busy)
    );

    function automatic int eff_len();
        return (c_len < 5'd3) ? 4 : int'(c_len) + 1;
    endfunction

    function automatic logic [31:0] lmask(input int l);
        return (l == 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // FIFO model and divider: inputs change only at the falling edge
    always @(negedge clk) begin
        if (pop_pend && txq.size() > 0) begin
            void'(txq.pop_front());
            n_pop++;
        end
        tx_empty = (txq.size() == 0);
        tx_data  = tx_empty ? 32'h0 : txq[0];
        divc = (divc == DIV - 1) ? 0 : divc + 1;
        sclk_tick = (divc == 0);
        #1;
        pop_pend = tx_pop;
    end

    // serial monitor and slave model
    logic pv_sclk = 1'b0, pv_cs = 1'b1, pv_mosi = 1'b0;
    logic [31:0] mbits = '0;
    int mcnt = 0, sbit = 0;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            int l;
            logic lead;
            l = eff_len();
            if (!pv_cs && cs_n) cs_rise++;
            if (pv_cs && !cs_n) begin
                mcnt = 0; mbits = '0;
                if (!c_cpha) begin miso = SLV[l-1]; sbit = l - 2; end
                else sbit = l - 1;
            end else if (!cs_n && !pv_cs && sclk != pv_sclk) begin
                lead = (pv_sclk == c_cpol);
                if (c_cpha ? !lead : lead) begin
                    mbits = {mbits[30:0], pv_mosi};
                    mcnt++;
                    if (mcnt == l) begin
                        if (exp_mosi.size() == 0) chk(0, "R2/R6 unexpected mosi word", mbits, 0);
                        else begin
                            logic [31:0] e;
                            e = exp_mosi.pop_front();
                            chk(mbits == e, "R2/R6 mosi word", mbits, e);
                        end
                        mcnt = 0; mbits = '0;
                    end
                end else begin
                    miso = SLV[sbit];
                    sbit = (sbit == 0) ? l - 1 : sbit - 1;
                end
            end
            if (rx_push) begin
                n_push++;
                if (exp_rx.size() == 0) chk(0, "R3/R4 unexpected rx word", rx_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_rx.pop_front();
                    chk(rx_data == e, "R3/R4/R7 rx word", rx_data, e);
                end
            end
        end
        pv_sclk = sclk; pv_cs = cs_n; pv_mosi = mosi;
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            summary();
        end
    end

    task automatic send(input logic [31:0] w);
        int l;
        l = eff_len();
        txq.push_back(w);
        exp_mosi.push_back(w & lmask(l));
        exp_rx.push_back(c_loop ? (w & lmask(l)) : (SLV & lmask(l)));
    endtask

    task automatic wait_done(input string tag);
        int t;
        t = 0;
        while (!(txq.size() == 0 && cs_n && !busy) && t < 20000) begin
            @(negedge clk); t++;
        end
        repeat (10) @(negedge clk);
        chk(exp_rx.size() == 0 && exp_mosi.size() == 0, tag, exp_rx.size(), 0);
    endtask

    task automatic set_cfg(input logic lp, input logic pol, input logic pha, input logic [4:0] lc);
        @(negedge clk);
        c_loop = lp; c_cpol = pol; c_cpha = pha; c_len = lc;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int p0, q0, r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        chk(busy == 1'b0 && tx_pop == 1'b0 && rx_push == 1'b0, "R1 busy/pop/push after reset",
            {busy, tx_pop, rx_push}, 0);
        en = 1'b1;

        // burst of 3 words, 8 bits, polarity 0 phase 0
        set_cfg(0, 0, 0, 5'd7);
        r0 = cs_rise;
        send(32'h0000_00A7); send(32'h1234_5601); send(32'hFFFF_FF3C);
        wait_done("R2/R3 burst mode 0");
        chk(cs_rise - r0 == 1, "R12 one select per burst", cs_rise - r0, 1);

        // polarity 1 phase 1, 16 bits
        set_cfg(0, 1, 1, 5'd15);
        chk(sclk == 1'b1, "R5 idle level high", sclk, 1);
        send(32'hDEAD_8001); send(32'h0000_4B2D);
        wait_done("R2/R6 mode 3");

        // loopback, phase 1, 32 bits
        set_cfg(1, 0, 1, 5'd31);
        chk(sclk == 1'b0, "R5 idle level low", sclk, 0);
        send(32'h8765_4321); send(32'h0F1E_2D3C);
        wait_done("R4/R7 loopback 32-bit");

        // loopback, polarity 1 phase 0, length code below minimum -> 4 bits
        set_cfg(1, 1, 0, 5'd1);
        send(32'hFFFF_FFF9); send(32'h0000_0006);
        wait_done("R4/R7 clamp to 4 bits");

        // 4 bits from MISO, phase 0
        set_cfg(0, 0, 0, 5'd3);
        send(32'h0000_000B);
        wait_done("R3/R7 4-bit word");

        // mode bit 0: nothing starts
        @(negedge clk); c_mode = 1'b0;
        p0 = n_pop;
        send(32'h0000_005A);
        repeat (120) @(negedge clk);
        chk(cs_n == 1'b1, "R11 no select with mode 0", cs_n, 1);
        chk(n_pop == p0, "R11 no pop with mode 0", n_pop, p0);
        c_mode = 1'b1;
        wait_done("R11 starts after mode set");

        // enable cleared during first word of a burst
        set_cfg(0, 1, 0, 5'd7);
        p0 = n_pop; q0 = n_push;
        send(32'h0000_00C1); send(32'h0000_0072); send(32'h0000_0019);
        while (n_pop == p0) @(negedge clk);
        en = 1'b0;
        repeat (300) @(negedge clk);
        #1;
        chk(n_pop - p0 == 1, "R10 single pop after disable", n_pop - p0, 1);
        chk(n_push - q0 == 1, "R10 word in flight completed", n_push - q0, 1);
        chk(txq.size() == 2, "R10 FIFO contents kept", txq.size(), 2);
        chk(cs_n == 1'b1, "R10 select released", cs_n, 1);
        chk(busy == 1'b0, "R9 idle and disabled not busy", busy, 0);
        @(negedge clk);
        en = 1'b1;
        #1;
        chk(busy == 1'b1, "R9 busy on pending data", busy, 1);
        wait_done("R10 rest of burst after enable");

        chk(n_push == n_pop, "R8 one received per sent", n_push, n_pop);
        summary();
    end
endmodule